// File: doc/BRIEF.md
# TDM Receive Timing and Deserializer

This block is the receive front end of a time-division-multiplexed switch. It takes one clock at twice the bit rate and an active-low frame pulse, and from them it keeps a free-running frame position. A frame lasts 512 clock cycles: 32 channels of 8 bits, each bit two clocks wide. Eight serial input streams are received in parallel. Each finished 8-bit channel byte is written into a 256 x 8 data memory at the location for its stream and channel.

The output path reads that memory through a registered read port. It also uses the exported channel number, bit number and half-bit phase to time its own transmission. A low frame pulse seen at a clock edge restarts the frame at that edge, so the frame can be realigned at any point. Without a pulse the count wraps by itself.

Top module: `tdm_rx_frontend`

## Requirements
- R1: An active-low asynchronous reset clears all counters and registers: channel 0, bit number 7, half phase 0, and read data 0.
- R2: When `fp_n` is low at a rising clock edge, the next cycle is the first cycle of a frame (channel 0, bit number 7, half 0), whatever the previous position was.
- R3: With `fp_n` high, the half phase toggles every cycle. The bit number steps down by one (7 to 0) after each second half. The channel steps up by one after the second half of bit 0. After channel 31, bit 0, half 1 the count returns to the frame start without a pulse, so a frame is 512 cycles.
- R4: Each stream's input is sampled once per bit cell, on the rising edge that ends the first half (half phase 0) of that cell.
- R5: Bytes arrive most significant bit first: the first bit sampled in a channel becomes bit 7 of the stored byte.
- R6: The byte received on stream s during channel c is stored at data memory address {s[2:0], c[4:0]}, that is, s*32 + c.
- R7: The write happens on the edge that ends the channel's last cycle (bit 0, half 1), one cycle after the last sample. A read taken on that same edge returns the old contents; a read on the next edge returns the new byte.
- R8: `rd_data` is registered. It shows the memory location at `rd_addr` as captured on the previous rising edge.
- R9: All eight streams are received at the same time, and each stream's bytes are independent of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse; a low level restarts the frame count |
| si | input | 8 | Serial data, one bit per input stream |
| rd_addr | input | 8 | Data memory read address {stream, channel} |
| rd_data | output | 8 | Registered read data |
| chan_o | output | 5 | Current channel number within the frame |
| bit_o | output | 3 | Number of the bit currently arriving (7 first) |
| half_o | output | 1 | Half phase of the current bit cell (0 first) |

## Verification
A wrong frame count shows on `chan_o`, `bit_o` and `half_o` in the very next cycle, so every cycle of a frame is compared with the position expected since the last pulse. Problems in the shift path are caught later, through the memory. A sampling phase off by one, a reversed bit order or a wrong stream or channel index only appears when stored bytes are read back. These faults show up within one frame as rotated, mirrored or misplaced bytes across four data patterns. A write landing one cycle early or late is caught by reading the target location on the exact write edge and on the edge after it. Realignment in the middle of a frame and a mid-run reset are also checked at the ports.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
    localparam int unsigned DEF_STREAMS = 8;
    localparam int unsigned DEF_CHANS   = 32;
    localparam int unsigned DEF_BITS    = 8;

    // Strobes from the frame timer to the deserializer
    typedef struct packed {
        logic smp;   // sample edge (end of first half of a bit cell)
        logic last;  // sample edge of the final bit of a channel
    } tdm_tick_t;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_rx_pkg::*;
#(
    parameter int unsigned CHANS = DEF_CHANS,
    parameter int unsigned BITS  = DEF_BITS,
    localparam int unsigned CW   = $clog2(CHANS),
    localparam int unsigned BW   = $clog2(BITS),
    localparam int unsigned CNTW = CW + BW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fp_n,
    output logic [CW-1:0] chan_o,
    output logic [BW-1:0] bit_o,
    output logic          half_o,
    output tdm_tick_t     tick_o
);
    typedef struct packed {
        logic [CNTW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic [BW-1:0] idx;

    always_comb begin
        st_d = st_q;
        if (!fp_n) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx         = st_q.cnt[BW:1];
    assign chan_o      = st_q.cnt[CNTW-1:BW+1];
    assign bit_o       = ~idx;
    assign half_o      = st_q.cnt[0];
    assign tick_o.smp  = ~st_q.cnt[0];
    assign tick_o.last = ~st_q.cnt[0] & (&idx);
endmodule

// File: rtl/tdm_deser.sv
module tdm_deser
    import tdm_rx_pkg::*;
#(
    parameter int unsigned STREAMS = DEF_STREAMS,
    parameter int unsigned CHANS   = DEF_CHANS,
    parameter int unsigned BITS    = DEF_BITS,
    localparam int unsigned CW     = $clog2(CHANS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [STREAMS-1:0]             si,
    input  tdm_tick_t                      tick,
    input  logic [CW-1:0]                  chan,
    output logic                           wr_en,
    output logic [CW-1:0]                  wr_chan,
    output logic [STREAMS-1:0][BITS-1:0]   wr_data
);
    typedef struct packed {
        logic [STREAMS-1:0][BITS-1:0] shf;
        logic [STREAMS-1:0][BITS-1:0] hold;
        logic                         wr;
        logic [CW-1:0]                wch;
    } des_st_t;

    des_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        if (tick.smp) begin
            for (int s = 0; s < STREAMS; s++) begin
                st_d.shf[s] = {st_q.shf[s][BITS-2:0], si[s]};
            end
            if (tick.last) begin
                st_d.hold = st_d.shf;
                st_d.wr   = 1'b1;
                st_d.wch  = chan;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = st_q.wr;
    assign wr_chan = st_q.wch;
    assign wr_data = st_q.hold;
endmodule

// File: rtl/tdm_data_mem.sv
module tdm_data_mem
    import tdm_rx_pkg::*;
#(
    parameter int unsigned STREAMS = DEF_STREAMS,
    parameter int unsigned CHANS   = DEF_CHANS,
    parameter int unsigned BITS    = DEF_BITS,
    localparam int unsigned SW     = $clog2(STREAMS),
    localparam int unsigned CW     = $clog2(CHANS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CW-1:0]                wr_chan,
    input  logic [STREAMS-1:0][BITS-1:0] wr_data,
    input  logic [SW+CW-1:0]             rd_addr,
    output logic [BITS-1:0]              rd_data
);
    logic [STREAMS-1:0][BITS-1:0] bank_rd;
    logic [BITS-1:0] rd_d, rd_q;

    // One bank per stream so all streams commit in the same edge
    for (genvar b = 0; b < STREAMS; b++) begin : g_bank
        logic [BITS-1:0] cells [CHANS];

        always_ff @(posedge clk) begin
            if (wr_en) begin
                cells[wr_chan] <= wr_data[b];
            end
        end

        assign bank_rd[b] = cells[rd_addr[CW-1:0]];
    end

    always_comb begin
        rd_d = bank_rd[rd_addr[SW+CW-1:CW]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/tdm_rx_frontend.sv
module tdm_rx_frontend
    import tdm_rx_pkg::*;
#(
    parameter int unsigned STREAMS = DEF_STREAMS,
    parameter int unsigned CHANS   = DEF_CHANS,
    parameter int unsigned BITS    = DEF_BITS,
    localparam int unsigned SW     = $clog2(STREAMS),
    localparam int unsigned CW     = $clog2(CHANS),
    localparam int unsigned BW     = $clog2(BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fp_n,
    input  logic [STREAMS-1:0] si,
    input  logic [SW+CW-1:0]   rd_addr,
    output logic [BITS-1:0]    rd_data,
    output logic [CW-1:0]      chan_o,
    output logic [BW-1:0]      bit_o,
    output logic               half_o
);
    tdm_tick_t                    tick;
    logic                         wr_en;
    logic [CW-1:0]                wr_chan;
    logic [STREAMS-1:0][BITS-1:0] wr_data;

    tdm_frame_timer #(
        .CHANS (CHANS),
        .BITS  (BITS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .fp_n   (fp_n),
        .chan_o (chan_o),
        .bit_o  (bit_o),
        .half_o (half_o),
        .tick_o (tick)
    );

    tdm_deser #(
        .STREAMS (STREAMS),
        .CHANS   (CHANS),
        .BITS    (BITS)
    ) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .si      (si),
        .tick    (tick),
        .chan    (chan_o),
        .wr_en   (wr_en),
        .wr_chan (wr_chan),
        .wr_data (wr_data)
    );

    tdm_data_mem #(
        .STREAMS (STREAMS),
        .CHANS   (CHANS),
        .BITS    (BITS)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_chan (wr_chan),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/tdm_rx_checker.sv
module tdm_rx_checker #(
    parameter int unsigned CW = 5,
    parameter int unsigned BW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fp_n,
    input logic [CW-1:0] chan,
    input logic [BW-1:0] bitn,
    input logic          half,
    input logic          wr_en
);
    // R2: a low frame pulse restarts the frame on the next cycle
    p_frame_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_n |=> (chan == '0 && bitn == '1 && !half));

    // R3: half phase alternates every cycle while free running
    p_half_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fp_n |=> (half != $past(half)));

    // R3: bit number steps down after each second half
    p_bit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_n && half) |=> (bitn == $past(bitn) - 1'b1));

    // R3: channel advances after the second half of the final bit
    p_chan_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_n && half && bitn == '0) |=> (chan == $past(chan) + 1'b1));

    // R4: position holds through the first half of a bit cell
    p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_n && !half) |=> ($stable(bitn) && $stable(chan)));

    // R7: memory writes only occur in the final cycle of a channel
    p_write_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(fp_n)) |-> (bitn == '0 && half));
endmodule

bind tdm_rx_frontend tdm_rx_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .fp_n  (fp_n),
    .chan  (chan_o),
    .bitn  (bit_o),
    .half  (half_o),
    .wr_en (wr_en)
);

// File: tb/tb_tdm_rx_frontend.sv
module tb_tdm_rx_frontend;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fp_n;
    logic [7:0] si;
    logic [7:0] rd_addr;
    wire  [7:0] rd_data;
    wire  [4:0] chan_o;
    wire  [2:0] bit_o;
    wire        half_o;

    int  errs   = 0;
    int  checks = 0;
    bit  done   = 1'b0;
    logic [7:0] rlog [0:511];

    always #2 clk = ~clk;

    tdm_rx_frontend dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .fp_n    (fp_n),
        .si      (si),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .chan_o  (chan_o),
        .bit_o   (bit_o),
        .half_o  (half_o)
    );

    function automatic logic [7:0] pat(input int sel, input logic [7:0] a);
        case (sel)
            0:       pat = a;
            1:       pat = ~a;
            2:       pat = (a * 8'd29) ^ 8'h5A;
            3:       pat = {a[0], a[7:1]} + 8'h33;
            default: pat = a ^ 8'hC3;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives len slots of a frame from count 0; rlog[k] is rd_data seen in slot k.
    task automatic run_frame(input int sel, input int len, input bit pulse_end,
                             input bit sweep, input logic [7:0] probe, input bit chk_cnt);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rlog[k] = rd_data;
            if (chk_cnt) begin
                int exp_pos;
                exp_pos = ((k >> 4) << 4) | ((7 - ((k >> 1) & 7)) << 1) | (k & 1);
                check(int'({chan_o, bit_o, half_o}) == exp_pos,
                      (k == 0) ? "R2/R3 frame start" : "R3 frame position",
                      int'({chan_o, bit_o, half_o}), exp_pos);
            end
            for (int s = 0; s < 8; s++) begin
                logic [7:0] byt;
                byt   = pat(sel, {s[2:0], k[8:4]});
                si[s] = byt[7 - ((k >> 1) & 7)];
            end
            fp_n    = !(pulse_end && (k == len - 1));
            rd_addr = sweep ? k[7:0] : probe;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; fp_n = 1'b1; si = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        check({chan_o, bit_o, half_o} == 9'b00000_111_0, "R1 reset position",
              int'({chan_o, bit_o, half_o}), 9'b00000_111_0);
        check(rd_data == 8'h00, "R1 reset read data", rd_data, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_counter();
        run_frame(0, 1, 1'b1, 1'b0, 8'h00, 1'b0);   // align
        run_frame(0, 512, 1'b0, 1'b0, 8'h00, 1'b1); // no pulse at end: wrap
        run_frame(0, 512, 1'b1, 1'b0, 8'h00, 1'b1);
    endtask

    // R4 R5 R6 R8 R9: fill with a pattern, then sweep-read all 256 locations
    task automatic t_store(input int sel);
        run_frame(sel, 512, 1'b1, 1'b0, 8'h00, 1'b0);
        run_frame(sel, 512, 1'b1, 1'b1, 8'h00, 1'b0);
        for (int k = 1; k <= 256; k++) begin
            logic [7:0] a;
            a = 8'(k - 1);
            check(rlog[k] == pat(sel, a), "R6 stream/channel store", rlog[k], pat(sel, a));
        end
        check(rlog[8'h93 + 1] == pat(sel, 8'h93), "R5 msb-first byte", rlog[8'h94], pat(sel, 8'h93));
    endtask

    // R7: stream 5 channel 9 written on the edge ending slot 159
    task automatic t_write_slot();
        logic [7:0] a;
        a = {3'd5, 5'd9};
        run_frame(4, 512, 1'b1, 1'b0, a, 1'b0);
        check(rlog[160] == pat(3, a), "R7 read on write edge gives old", rlog[160], pat(3, a));
        check(rlog[161] == pat(4, a), "R7 read after write edge gives new", rlog[161], pat(4, a));
    endtask

    task automatic t_realign();
        run_frame(2, 201, 1'b1, 1'b0, 8'h00, 1'b0);  // pulse in mid frame
        run_frame(2, 512, 1'b1, 1'b0, 8'h00, 1'b1);
        run_frame(2, 512, 1'b1, 1'b1, 8'h00, 1'b0);
        for (int k = 1; k <= 256; k++) begin
            logic [7:0] a;
            a = 8'(k - 1);
            check(rlog[k] == pat(2, a), "R2 realigned store", rlog[k], pat(2, a));
        end
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({chan_o, bit_o, half_o} == 9'b00000_111_0, "R1 mid-run reset position",
              int'({chan_o, bit_o, half_o}), 9'b00000_111_0);
        check(rd_data == 8'h00, "R1 mid-run reset read data", rd_data, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_counter();
        t_store(0);
        t_store(1);
        t_store(2);
        t_store(3);
        t_write_slot();
        t_realign();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule